// File: doc/BRIEF.md
# Bidirectional Tape Position Timer

This block turns tachometer pulses from moving tape into a running play-time count. Each pulse stands for a fixed length of tape. A fractional accumulator converts that length to time at the selected tape speed. Whenever the accumulator crosses its modulus, a tenth of a second is added to the count, or taken from it. The count is held in BCD fields: tenths, seconds (0–59), minutes (0–59) and hours (0–9). It moves forward or backward with the transport direction. A pushbutton input sets both the count and the accumulator to zero, and later motion is measured from that point.

The count is shown on a remote five-digit display, one digit at a time. A 4-bit BCD bus is shared by all five digits, and five active-low digit strobes mark which digit is on the bus. A format input picks between hours:minutes:seconds and minutes:seconds.tenths. A scan state machine with the states SCAN_D1, SCAN_D2, SCAN_D3, SCAN_D4 and SCAN_D5 steps through the digits in order, from SCAN_D5 back to SCAN_D1. It leaves each state after `SCAN_DIV` clock cycles. The bus value and its strobe are registered together, on the same clock edge.

Top module: `tape_timer`

## Requirements
- R1: A one-cycle high on `zero_req` clears every count field and the fraction accumulator on the next clock edge.
- R2: Each cycle with `tach_pulse` high adds a step to an accumulator of modulus `ACC_MOD`. The step is `INC_BASE` times 8, 4, 2 or 1 for `speed_sel` codes 0, 1, 2 and 3 (3.75, 7.5, 15 and 30 in/s). Reaching the modulus subtracts it from the accumulator and adds one tenth of a second to the count.
- R3: With `dir_rev` = 1 a pulse subtracts the step instead. If the accumulator is smaller than the step, the modulus is added back and one tenth is removed from the count.
- R4: Tenths and the units digits count 0–9, and the tens of seconds and tens of minutes count 0–5. Each field carries into the next field up, or borrows from it.
- R5: Moving back past zero wraps to the largest value of the active format: 9:59:59.9 when `fmt_short` = 0, and 59:59.9 when `fmt_short` = 1, with the hours left unchanged. Moving forward past that value wraps to zero.
- R6: With `fmt_short` = 0 the digits 1 to 5 show hours, tens of minutes, units of minutes, tens of seconds and units of seconds. With `fmt_short` = 1 they show tens of minutes, units of minutes, tens of seconds, units of seconds and tenths.
- R7: Exactly one bit of `dsel_n` is low at all times. Bit 0 stands for digit 1, and reset leaves `dsel_n` = 5'b11110 and `bcd_bus` = 0.
- R8: The low strobe moves from digit 1 up to digit 5 and then back to digit 1. It stays on each digit for exactly `SCAN_DIV` cycles.
- R9: In every cycle `bcd_bus` carries the digit that the low strobe selects, taken from the count and format of the previous cycle. The bus and the strobe change on the same edge.
- R10: When `zero_req` and `tach_pulse` are high in the same cycle, the clear wins and the pulse is discarded, whatever carry or borrow it would have caused.
- R11: In a cycle with neither `tach_pulse` nor `zero_req`, the count does not change. This holds across format changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tach_pulse | input | 1 | Tachometer pulse, high for one cycle per pulse |
| dir_rev | input | 1 | 1 = tape moving in reverse |
| speed_sel | input | 2 | Tape speed code: 0=3.75, 1=7.5, 2=15, 3=30 in/s |
| zero_req | input | 1 | Zero pushbutton, synchronous, one cycle |
| fmt_short | input | 1 | 0 = H:MM:SS, 1 = MM:SS.t |
| bcd_bus | output | 4 | Shared BCD digit bus |
| dsel_n | output | 5 | Active-low digit strobes, bit 0 = digit 1 |

## Verification
Two things can land on the same clock edge: the zero pushbutton and a tachometer pulse whose step would carry or borrow a tenth. The bench drives both inputs high in one cycle, once while counting forward and once in reverse at a speed that forces an underflow. The result must be a display of all zeros. A following pulse must then behave like the first pulse from a clean accumulator, with no carry left over. The digit scan runs the whole time, and every read also checks that the bus value matches the strobe at the first cycle of each dwell.

// File: rtl/tape_timer_pkg.sv
package tape_timer_pkg;

    localparam int DISP_DIGITS = 5;
    localparam int FIELD_COUNT = 6;

    typedef enum logic [2:0] {
        SCAN_D1 = 3'd0,
        SCAN_D2 = 3'd1,
        SCAN_D3 = 3'd2,
        SCAN_D4 = 3'd3,
        SCAN_D5 = 3'd4
    } scan_state_t;

    typedef enum logic [1:0] {
        SPD_3P75 = 2'd0,
        SPD_7P5  = 2'd1,
        SPD_15   = 2'd2,
        SPD_30   = 2'd3
    } speed_t;

    // tenths occupies the low nibble, hours the high nibble
    typedef struct packed {
        logic [3:0] hours;
        logic [3:0] min_tens;
        logic [3:0] min_ones;
        logic [3:0] sec_tens;
        logic [3:0] sec_ones;
        logic [3:0] tenths;
    } play_time_t;

    function automatic logic [3:0] shown_digit(play_time_t t, logic fmt_short,
                                               scan_state_t pos);
        logic [3:0] d;
        d = 4'd0;
        unique case (pos)
            SCAN_D1: d = fmt_short ? t.min_tens : t.hours;
            SCAN_D2: d = fmt_short ? t.min_ones : t.min_tens;
            SCAN_D3: d = fmt_short ? t.sec_tens : t.min_ones;
            SCAN_D4: d = fmt_short ? t.sec_ones : t.sec_tens;
            SCAN_D5: d = fmt_short ? t.tenths   : t.sec_ones;
            default: d = 4'd0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tt_tach_scaler.sv
module tt_tach_scaler
    import tape_timer_pkg::*;
#(
    parameter int ACC_MOD  = 48,
    parameter int INC_BASE = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tach_pulse,
    input  logic       dir_rev,
    input  logic [1:0] speed_sel,
    input  logic       zero_req,
    output logic       tenth_up,
    output logic       tenth_dn
);
    localparam int ACC_W = $clog2(2 * ACC_MOD + 1);
    localparam logic [ACC_W-1:0] MOD_V   = ACC_W'(ACC_MOD);
    localparam logic [ACC_W-1:0] STEP_S0 = ACC_W'(INC_BASE * 8);
    localparam logic [ACC_W-1:0] STEP_S1 = ACC_W'(INC_BASE * 4);
    localparam logic [ACC_W-1:0] STEP_S2 = ACC_W'(INC_BASE * 2);
    localparam logic [ACC_W-1:0] STEP_S3 = ACC_W'(INC_BASE);

    logic [ACC_W-1:0] acc_q, acc_d, step, sum;
    logic             wrap;

    always_comb begin
        unique case (speed_t'(speed_sel))
            SPD_3P75: step = STEP_S0;
            SPD_7P5:  step = STEP_S1;
            SPD_15:   step = STEP_S2;
            SPD_30:   step = STEP_S3;
            default:  step = STEP_S3;
        endcase
    end

    always_comb begin
        sum  = acc_q + step;
        wrap = 1'b0;
        if (dir_rev) begin
            if (acc_q >= step) begin
                acc_d = acc_q - step;
            end else begin
                acc_d = (acc_q + MOD_V) - step;
                wrap  = 1'b1;
            end
        end else begin
            if (sum >= MOD_V) begin
                acc_d = sum - MOD_V;
                wrap  = 1'b1;
            end else begin
                acc_d = sum;
            end
        end
    end

    assign tenth_up = tach_pulse & ~zero_req & ~dir_rev & wrap;
    assign tenth_dn = tach_pulse & ~zero_req &  dir_rev & wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (zero_req) begin
            acc_q <= '0;
        end else if (tach_pulse) begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/tt_bcd_digit.sv
module tt_bcd_digit #(
    parameter logic [3:0] MAXV = 4'd9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       enable,
    input  logic       inc,
    input  logic       dec,
    output logic [3:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 4'd0;
        end else if (clear) begin
            q <= 4'd0;
        end else if (enable && inc) begin
            q <= (q == MAXV) ? 4'd0 : q + 4'd1;
        end else if (enable && dec) begin
            q <= (q == 4'd0) ? MAXV : q - 4'd1;
        end
    end
endmodule

// File: rtl/tt_time_counter.sv
module tt_time_counter
    import tape_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       zero_req,
    input  logic       fmt_short,
    input  logic       tenth_up,
    input  logic       tenth_dn,
    output play_time_t now
);
    logic [4*FIELD_COUNT-1:0] fields;
    logic [FIELD_COUNT-1:0]   inc_c;
    logic [FIELD_COUNT-1:0]   dec_c;

    assign inc_c[0] = tenth_up;
    assign dec_c[0] = tenth_dn;

    for (genvar i = 0; i < FIELD_COUNT; i++) begin : g_field
        localparam logic [3:0] LIM = (i == 2 || i == 4) ? 4'd5 : 4'd9;
        logic en;
        if (i == FIELD_COUNT - 1) begin : g_hours
            assign en = ~fmt_short;
        end else begin : g_lower
            assign en = 1'b1;
        end
        tt_bcd_digit #(.MAXV(LIM)) u_digit (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (zero_req),
            .enable (en),
            .inc    (inc_c[i]),
            .dec    (dec_c[i]),
            .q      (fields[4*i +: 4])
        );
        if (i < FIELD_COUNT - 1) begin : g_chain
            assign inc_c[i+1] = inc_c[i] & (fields[4*i +: 4] == LIM);
            assign dec_c[i+1] = dec_c[i] & (fields[4*i +: 4] == 4'd0);
        end
    end

    assign now = play_time_t'(fields);

endmodule

// File: rtl/tt_digit_scan.sv
module tt_digit_scan
    import tape_timer_pkg::*;
#(
    parameter int SCAN_DIV = 1024
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  play_time_t             now,
    input  logic                   fmt_short,
    output logic [3:0]             bcd_bus,
    output logic [DISP_DIGITS-1:0] dsel_n
);
    localparam int DIV_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCAN_DIV - 1);

    scan_state_t            state_q, state_d;
    logic [DIV_W-1:0]       div_q;
    logic                   dwell_done;
    logic [DISP_DIGITS-1:0] sel_d;

    assign dwell_done = (div_q == DIV_LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCAN_D1: if (dwell_done) state_d = SCAN_D2;
            SCAN_D2: if (dwell_done) state_d = SCAN_D3;
            SCAN_D3: if (dwell_done) state_d = SCAN_D4;
            SCAN_D4: if (dwell_done) state_d = SCAN_D5;
            SCAN_D5: if (dwell_done) state_d = SCAN_D1;
            default: state_d = SCAN_D1;
        endcase
    end

    always_comb begin
        unique case (state_d)
            SCAN_D1: sel_d = 5'b11110;
            SCAN_D2: sel_d = 5'b11101;
            SCAN_D3: sel_d = 5'b11011;
            SCAN_D4: sel_d = 5'b10111;
            SCAN_D5: sel_d = 5'b01111;
            default: sel_d = 5'b11110;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SCAN_D1;
            div_q   <= '0;
        end else begin
            state_q <= state_d;
            div_q   <= dwell_done ? '0 : div_q + 1'b1;
        end
    end

    // outputs: bus and strobe taken from the same next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcd_bus <= 4'd0;
            dsel_n  <= 5'b11110;
        end else begin
            bcd_bus <= shown_digit(now, fmt_short, state_d);
            dsel_n  <= sel_d;
        end
    end

endmodule

// File: rtl/tape_timer.sv
module tape_timer
    import tape_timer_pkg::*;
#(
    parameter int ACC_MOD  = 48,
    parameter int INC_BASE = 3,
    parameter int SCAN_DIV = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tach_pulse,
    input  logic       dir_rev,
    input  logic [1:0] speed_sel,
    input  logic       zero_req,
    input  logic       fmt_short,
    output logic [3:0] bcd_bus,
    output logic [4:0] dsel_n
);
    logic       tenth_up, tenth_dn;
    play_time_t time_q;

    tt_tach_scaler #(.ACC_MOD(ACC_MOD), .INC_BASE(INC_BASE)) u_scaler (
        .clk        (clk),
        .rst_n      (rst_n),
        .tach_pulse (tach_pulse),
        .dir_rev    (dir_rev),
        .speed_sel  (speed_sel),
        .zero_req   (zero_req),
        .tenth_up   (tenth_up),
        .tenth_dn   (tenth_dn)
    );

    tt_time_counter u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .zero_req  (zero_req),
        .fmt_short (fmt_short),
        .tenth_up  (tenth_up),
        .tenth_dn  (tenth_dn),
        .now       (time_q)
    );

    tt_digit_scan #(.SCAN_DIV(SCAN_DIV)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .now       (time_q),
        .fmt_short (fmt_short),
        .bcd_bus   (bcd_bus),
        .dsel_n    (dsel_n)
    );

endmodule

// File: rtl/tape_timer_checker.sv
module tape_timer_checker
    import tape_timer_pkg::*;
#(
    parameter int SCAN_DIV = 1024
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tach_pulse,
    input logic       zero_req,
    input logic       fmt_short,
    input logic [3:0] bcd_bus,
    input logic [4:0] dsel_n,
    input play_time_t now
);
    logic [4:0]  dsel_q;
    int unsigned dwell;
    play_time_t  now_q;
    logic        fmt_q;
    scan_state_t pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dsel_q <= 5'b11110;
            dwell  <= 0;
            now_q  <= '0;
            fmt_q  <= 1'b0;
        end else begin
            dsel_q <= dsel_n;
            dwell  <= (dsel_n != dsel_q) ? 1 : dwell + 1;
            now_q  <= now;
            fmt_q  <= fmt_short;
        end
    end

    always_comb begin
        case (dsel_n)
            5'b11101: pos = SCAN_D2;
            5'b11011: pos = SCAN_D3;
            5'b10111: pos = SCAN_D4;
            5'b01111: pos = SCAN_D5;
            default:  pos = SCAN_D1;
        endcase
    end

    p_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        zero_req |=> (now == '0));

    p_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (now.sec_tens <= 4'd5) && (now.min_tens <= 4'd5) && (now.tenths <= 4'd9)
        && (now.sec_ones <= 4'd9) && (now.min_ones <= 4'd9) && (now.hours <= 4'd9));

    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~dsel_n) == 1);

    p_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dsel_n != dsel_q) |-> (dsel_n == {dsel_q[3:0], dsel_q[4]}));

    p_dwell_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dsel_n != dsel_q) |-> (dwell == SCAN_DIV));

    p_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_bus == shown_digit(now_q, fmt_q, pos));

    p_zero_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_req && tach_pulse) |=> (now == '0));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tach_pulse && !zero_req) |=> $stable(now));

endmodule

bind tape_timer tape_timer_checker #(.SCAN_DIV(SCAN_DIV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tach_pulse (tach_pulse),
    .zero_req   (zero_req),
    .fmt_short  (fmt_short),
    .bcd_bus    (bcd_bus),
    .dsel_n     (dsel_n),
    .now        (time_q)
);

// File: tb/tape_timer_test.sv
`timescale 1ns/1ps
module tape_timer_test;
    localparam int MOD  = 48;
    localparam int BASE = 3;
    localparam int DIV  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tach_pulse = 1'b0;
    logic       dir_rev = 1'b0;
    logic [1:0] speed_sel = 2'd0;
    logic       zero_req = 1'b0;
    logic       fmt_short = 1'b0;
    logic [3:0] bcd_bus;
    logic [4:0] dsel_n;

    int checks = 0;
    int errors = 0;
    int pos = 0;

    always #2.5 clk = ~clk;

    tape_timer #(.ACC_MOD(MOD), .INC_BASE(BASE), .SCAN_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .tach_pulse(tach_pulse), .dir_rev(dir_rev),
        .speed_sel(speed_sel), .zero_req(zero_req), .fmt_short(fmt_short),
        .bcd_bus(bcd_bus), .dsel_n(dsel_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int span_units(input bit fs);
        return (fs ? 36000 : 360000) * MOD;
    endfunction

    function automatic int exp_digit(input int k, input bit fs);
        int t, tn, s, m, h;
        t  = pos / MOD;
        tn = t % 10;
        s  = (t / 10) % 60;
        m  = (t / 600) % 60;
        h  = (t / 36000) % 10;
        if (fs) begin
            case (k)
                0: return m / 10;
                1: return m % 10;
                2: return s / 10;
                3: return s % 10;
                default: return tn;
            endcase
        end else begin
            case (k)
                0: return h;
                1: return m / 10;
                2: return m % 10;
                3: return s / 10;
                default: return s % 10;
            endcase
        end
    endfunction

    task automatic pulses(input int n, input bit rev, input int code);
        int st, sp;
        st = BASE << (3 - code);
        sp = span_units(fmt_short);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tach_pulse = 1'b1;
            dir_rev    = rev;
            speed_sel  = 2'(code);
            pos = rev ? (pos - st + sp) % sp : (pos + st) % sp;
            @(negedge clk);
            tach_pulse = 1'b0;
        end
    endtask

    task automatic zero_now();
        @(negedge clk);
        zero_req = 1'b1;
        @(negedge clk);
        zero_req = 1'b0;
        pos = 0;
    endtask

    // R9: each digit is sampled in the first cycle its strobe is low
    task automatic read_all(input string req);
        repeat (3) @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            logic [4:0] tgt;
            tgt = ~(5'b00001 << k);
            do @(negedge clk); while (dsel_n != tgt);
            check($sformatf("%s R9 digit%0d", req, k + 1), int'(bcd_bus),
                  exp_digit(k, fmt_short));
        end
    endtask

    task automatic scan_watch();
        logic [4:0] prev;
        int cnt;
        @(negedge clk);
        prev = dsel_n;
        do @(negedge clk); while (dsel_n == prev);
        for (int j = 0; j < 6; j++) begin
            prev = dsel_n;
            cnt  = 0;
            do begin
                @(negedge clk);
                cnt++;
            end while (dsel_n == prev);
            check("R8 dwell", cnt, DIV);
            check("R8 order", int'(dsel_n), int'({prev[3:0], prev[4]}));
            check("R7 onehot", $countones(~dsel_n), 1);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R7 reset strobe", int'(dsel_n), 5'b11110);
        check("R1 reset bus", int'(bcd_bus), 0);
        read_all("R1 reset");
        scan_watch();

        // R2: every speed code, forward
        for (int c = 0; c < 4; c++) begin
            zero_now();
            pulses(37 + c * 11, 1'b0, c);
            read_all($sformatf("R2 speed%0d", c));
        end

        // R3: reverse motion at two speeds
        zero_now();
        pulses(500, 1'b0, 0);
        pulses(123, 1'b1, 1);
        read_all("R3 rev7p5");
        pulses(77, 1'b1, 3);
        read_all("R3 rev30");

        // R4: seconds roll into minutes and borrow back
        zero_now();
        pulses(1200, 1'b0, 0);
        read_all("R4 carry");
        pulses(1, 1'b1, 0);
        read_all("R4 borrow");
        fmt_short = 1'b1;
        read_all("R6 short view");
        fmt_short = 1'b0;

        // R5: wraps in both formats
        zero_now();
        pulses(1, 1'b1, 0);
        read_all("R5 long under");
        pulses(1, 1'b0, 0);
        read_all("R5 long over");
        fmt_short = 1'b1;
        zero_now();
        pulses(1, 1'b1, 2);
        read_all("R5 short under");
        pulses(1, 1'b0, 2);
        read_all("R5 short over");

        // R11: count holds while idle and across a format change
        zero_now();
        pulses(40, 1'b0, 1);
        read_all("R11 before");
        repeat (50) @(negedge clk);
        fmt_short = 1'b0;
        read_all("R11 idle long");
        fmt_short = 1'b1;
        read_all("R11 idle short");

        // R10: zero and tach pulse in the same cycle
        pulses(3, 1'b0, 0);
        @(negedge clk);
        tach_pulse = 1'b1; dir_rev = 1'b0; speed_sel = 2'd0; zero_req = 1'b1;
        @(negedge clk);
        tach_pulse = 1'b0; zero_req = 1'b0;
        pos = 0;
        read_all("R10 fwd");
        @(negedge clk);
        tach_pulse = 1'b1; dir_rev = 1'b1; speed_sel = 2'd0; zero_req = 1'b1;
        @(negedge clk);
        tach_pulse = 1'b0; zero_req = 1'b0;
        pos = 0;
        read_all("R10 rev");
        pulses(1, 1'b0, 0);
        read_all("R10 clean acc one");
        pulses(1, 1'b0, 0);
        read_all("R10 clean acc two");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule